// File: doc/BRIEF.md
# Phase-Frequency Detector Pump Control with Lock Detection

This block is the digital half of a PLL's phase comparator. It watches two logic-level clocks, the divided oscillator clock and the reference clock, and compares their falling edges. All of its logic runs on the crystal clock. When the divided-clock edge comes first, it enables the sourcing (UP) side of an external charge pump. When the reference edge comes first, it enables the sinking (DOWN) side. Each enable lasts for the phase gap, measured in crystal-clock cycles. When neither side drives, the pump is reported as high-impedance. A 2-bit current-select code and a forced-idle test code come from control bits.

A lock monitor measures how long each net pump pulse lasts. A pulse longer than one crystal cycle drops the lock flag at once. The flag returns only after eight reference periods in a row with no such pulse. The analog pump, the loop filter and the oscillator lie outside this block. Both input clocks are assumed to be synchronous to the crystal clock, or already synchronized to it.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: While `rst_n` is low (synchronous reset), at the next clock edge `pump_up`=0, `pump_dn`=0, `pump_hiz`=1 and `lock_flag`=0.
- R2: Case: a falling edge of `fdiv_in` is sampled d>=1 cycles before a falling edge of `fref_in`. Then `pump_up` is 1 for exactly d cycles, starting one cycle after the `fdiv_in` edge is sampled, and `pump_dn` stays 0.
- R3: Case: a falling edge of `fref_in` is sampled d>=1 cycles before a falling edge of `fdiv_in`. Then `pump_dn` is 1 for exactly d cycles, starting one cycle after the `fref_in` edge is sampled, and `pump_up` stays 0.
- R4: Falling edges of both inputs sampled on the same edge, with no pulse in progress, produce no pump pulse, and `pump_hiz` stays 1.
- R5: When the lagging edge is sampled, both internal enables are held for one cycle and then cleared together. From the cycle after the lagging edge is sampled, `pump_up`=`pump_dn`=0 and `pump_hiz`=1.
- R6: While `test_code` (bits {T2,T1,T0}) equals 3'b010, `pump_up`=`pump_dn`=0 and `pump_hiz`=1, whatever the input phases.
- R7: `pump_isel` equals {`cp_sel`, `test_code[0]`} at all times: code 0 is the lowest current and code 3 the highest.
- R8: A net pump pulse that is still active in its second consecutive cycle counts as wide. `lock_flag` goes to 0 one cycle after that second cycle.
- R9: `lock_flag` goes to 1 one cycle after the eighth consecutive clean `fref_in` falling edge is sampled. Reset counts as a start, and pulses of one cycle are clean.
- R10: A wide pulse resets the consecutive-clean count to zero. The reference period closed by the next `fref_in` falling edge does not count as clean, so eight further clean edges are needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock; all logic samples on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fdiv_in | input | 1 | Divided oscillator clock |
| fref_in | input | 1 | Reference clock |
| cp_sel | input | 1 | Upper bit of the pump current code |
| test_code | input | 3 | Test bits {T2,T1,T0}; 3'b010 forces high-impedance, bit 0 is the lower current bit |
| pump_up | output | 1 | Enable for the sourcing pump half |
| pump_dn | output | 1 | Enable for the sinking pump half |
| pump_hiz | output | 1 | Pump output is high-impedance |
| pump_isel | output | 2 | Pump current select code |
| lock_flag | output | 1 | Loop lock indication |

## Verification
The pump enables change one cycle after the edge that samples an input fall. They fall back one cycle after the lagging edge is sampled. Lock loss shows one cycle after the second cycle of a net pulse, and lock gain one cycle after the deciding reference edge is sampled. The current code and the forced-idle code are combinational, so they are checked on the next sample after a change. Inputs are driven on falling clock edges, and every output is logged per cycle on falling edges. Each expected item carries the exact cycle at which it is due, worked out from the cycle in which its stimulus was applied, and is compared against the log of that cycle.

// File: rtl/pfd_pkg.sv
// Package: shared constants and types of the phase detector block.
// Assumes: nothing beyond IEEE 1800-2017.
package pfd_pkg;
    // Test code that forces the pump into high-impedance.
    localparam logic [2:0] TEST_FORCE_HIZ = 3'b010;

    // Pump current select code (0 lowest .. 3 highest).
    typedef logic [1:0] pump_isel_t;

    // Channel indices inside the edge-detector vector.
    localparam int CH_DIV = 0;
    localparam int CH_REF = 1;
    localparam int N_CH   = 2;
endpackage

// File: rtl/pfd_fall_det.sv
// Module: per-channel falling-edge detector.
// Purpose: flags, for each input bit, a high-to-low transition between the
// last sampled value and the present value.
// Assumes: inputs are synchronous to clk. The history resets low, so an input
// must be seen high before a fall can be reported.
module pfd_fall_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_in,
    output logic [WIDTH-1:0] fall_out
);
    logic [WIDTH-1:0] hist_q;

    for (genvar ch = 0; ch < WIDTH; ch++) begin : g_ch
        // Purpose: keep last cycle's value of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) hist_q[ch] <= 1'b0;
            else        hist_q[ch] <= sig_in[ch];
        end

        // Purpose: a fall is old-high with new-low.
        always_comb fall_out[ch] = hist_q[ch] & ~sig_in[ch];
    end
endmodule

// File: rtl/pfd_phase_core.sv
// Module: phase/frequency comparison core.
// Purpose: sets the UP enable on a divided-clock fall and the DOWN enable on a
// reference fall. When both enables are high they are cleared together one
// cycle later. Coincident falls with no pulse in progress set neither.
// Assumes: edge strobes last one cycle. Falls that arrive during the clearing
// cycle are dropped, which needs input periods well above two cycles.
module pfd_phase_core (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_div,
    input  logic fall_ref,
    output logic up_q,
    output logic dn_q
);
    logic both_on;
    logic twin_fall;

    // Purpose: spot the overlap state and idle-time coincident edges.
    always_comb begin
        both_on   = up_q & dn_q;
        twin_fall = fall_div & fall_ref & ~up_q & ~dn_q;
    end

    // Purpose: enable state update with the shared clearing path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (both_on) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (!twin_fall) begin
            up_q <= up_q | fall_div;
            dn_q <= dn_q | fall_ref;
        end
    end

    // R2: a lone divided-clock fall from idle starts an UP pulse.
    assert_up_on_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_div && !fall_ref && !up_q && !dn_q) |=> (up_q && !dn_q));

    // R3: a lone reference fall from idle starts a DOWN pulse.
    assert_dn_on_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ref && !fall_div && !up_q && !dn_q) |=> (dn_q && !up_q));

    // R4: coincident falls from idle leave both enables off.
    assert_coincide_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_div && fall_ref && !up_q && !dn_q) |=> (!up_q && !dn_q));

    // R5: the overlap state lasts exactly one cycle.
    assert_overlap_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && dn_q) |=> (!up_q && !dn_q));
endmodule

// File: rtl/pfd_pump_decode.sv
// Module: pump output decode.
// Purpose: turns the core enables into net pump drive, the high-impedance
// indication and the current select code. The forced-idle test code wins
// over any phase result.
// Assumes: enables come straight from registers; the decode is combinational.
module pfd_pump_decode
    import pfd_pkg::*;
(
    input  logic       up_q,
    input  logic       dn_q,
    input  logic       cp_sel,
    input  logic [2:0] test_code,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_hiz,
    output pump_isel_t pump_isel
);
    logic force_idle;

    // Purpose: net drive direction and the idle indication.
    always_comb begin
        force_idle = (test_code == TEST_FORCE_HIZ);
        pump_up    = up_q & ~dn_q & ~force_idle;
        pump_dn    = dn_q & ~up_q & ~force_idle;
        pump_hiz   = ~(pump_up | pump_dn);
    end

    // Purpose: current code from the control bits.
    always_comb pump_isel = {cp_sel, test_code[0]};
endmodule

// File: rtl/pfd_lock_mon.sv
// Module: lock monitor.
// Purpose: measures each net pump pulse in clock cycles. A pulse longer than
// WIDE_LIMIT cycles clears the lock flag and the clean-period count at once.
// The flag is set when GOOD_PERIODS reference periods in a row end clean.
// Assumes: one reference fall strobe per reference period.
module pfd_lock_mon #(
    parameter int WIDE_LIMIT   = 1,
    parameter int GOOD_PERIODS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_q,
    input  logic dn_q,
    input  logic fall_ref,
    output logic lock_flag
);
    localparam int WCNT_W = (WIDE_LIMIT < 2) ? 1 : $clog2(WIDE_LIMIT + 1);
    localparam int GCNT_W = $clog2(GOOD_PERIODS + 1);
    localparam logic [WCNT_W-1:0] WIDE_AT   = WCNT_W'(WIDE_LIMIT);
    localparam logic [GCNT_W-1:0] GOOD_LAST = GCNT_W'(GOOD_PERIODS - 1);
    localparam logic [GCNT_W-1:0] GOOD_TOP  = GCNT_W'(GOOD_PERIODS);

    logic              net_on;
    logic              wide_evt;
    logic              period_clean;
    logic [WCNT_W-1:0] wcnt_q;
    logic [GCNT_W-1:0] gcnt_q;
    logic              bad_seen_q;
    logic              lock_q;

    // Purpose: net pulse, over-width event and clean period end.
    always_comb begin
        net_on       = up_q ^ dn_q;
        wide_evt     = net_on && (wcnt_q == WIDE_AT);
        period_clean = fall_ref && !bad_seen_q && !wide_evt;
    end

    // Purpose: saturating width counter of the running net pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !net_on)     wcnt_q <= '0;
        else if (wcnt_q < WIDE_AT) wcnt_q <= wcnt_q + 1'b1;
    end

    // Purpose: remember a wide pulse until the reference period closes.
    always_ff @(posedge clk) begin
        if (!rst_n)        bad_seen_q <= 1'b0;
        else if (fall_ref) bad_seen_q <= 1'b0;
        else if (wide_evt) bad_seen_q <= 1'b1;
    end

    // Purpose: consecutive clean reference period count.
    always_ff @(posedge clk) begin
        if (!rst_n || wide_evt) gcnt_q <= '0;
        else if (fall_ref) begin
            if (!period_clean)          gcnt_q <= '0;
            else if (gcnt_q < GOOD_TOP) gcnt_q <= gcnt_q + 1'b1;
        end
    end

    // Purpose: lock flag state.
    always_ff @(posedge clk) begin
        if (!rst_n || wide_evt)                      lock_q <= 1'b0;
        else if (period_clean && gcnt_q >= GOOD_LAST) lock_q <= 1'b1;
    end

    always_comb lock_flag = lock_q;

    // R8: an over-width pulse leaves the flag low on the next cycle.
    assert_wide_drops_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wide_evt |=> !lock_q);

    // R9: lock is only gained on the cycle after a reference fall.
    assert_lock_on_ref_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(fall_ref));

    // R10: an over-width pulse restarts the clean count.
    assert_wide_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wide_evt |=> (gcnt_q == '0));
endmodule

// File: rtl/pfd_lock_ctrl.sv
// Module: top of the phase detector with pump control and lock detection.
// Purpose: detects falling edges of both clocks, runs the comparison core,
// decodes the pump controls and judges lock from pulse width.
// Assumes: fdiv_in and fref_in are synchronous to clk (the crystal clock).
module pfd_lock_ctrl
    import pfd_pkg::*;
#(
    parameter int WIDE_LIMIT   = 1,
    parameter int GOOD_PERIODS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fdiv_in,
    input  logic       fref_in,
    input  logic       cp_sel,
    input  logic [2:0] test_code,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_hiz,
    output logic [1:0] pump_isel,
    output logic       lock_flag
);
    logic [N_CH-1:0] raw_in;
    logic [N_CH-1:0] fall_vec;
    logic            up_q;
    logic            dn_q;

    // Purpose: gather both clocks into the detector vector.
    always_comb begin
        raw_in[CH_DIV] = fdiv_in;
        raw_in[CH_REF] = fref_in;
    end

    pfd_fall_det #(.WIDTH(N_CH)) u_fall (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (raw_in),
        .fall_out (fall_vec)
    );

    pfd_phase_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_div (fall_vec[CH_DIV]),
        .fall_ref (fall_vec[CH_REF]),
        .up_q     (up_q),
        .dn_q     (dn_q)
    );

    pfd_pump_decode u_dec (
        .up_q      (up_q),
        .dn_q      (dn_q),
        .cp_sel    (cp_sel),
        .test_code (test_code),
        .pump_up   (pump_up),
        .pump_dn   (pump_dn),
        .pump_hiz  (pump_hiz),
        .pump_isel (pump_isel)
    );

    pfd_lock_mon #(
        .WIDE_LIMIT   (WIDE_LIMIT),
        .GOOD_PERIODS (GOOD_PERIODS)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_q      (up_q),
        .dn_q      (dn_q),
        .fall_ref  (fall_vec[CH_REF]),
        .lock_flag (lock_flag)
    );

    // R1: the cycle after a reset edge shows an idle pump and no lock.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!pump_up && !pump_dn && pump_hiz && !lock_flag));
endmodule

// File: tb/pfd_lock_ctrl_tb_top.sv
// Bench: scoreboard style. Driver tasks push expected items tagged with the
// cycle they are due. A monitor logs outputs every cycle and compares the
// due items against the log.
module pfd_lock_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fdiv_in = 1'b1;
    logic       fref_in = 1'b1;
    logic       cp_sel = 1'b0;
    logic [2:0] test_code = 3'b000;
    logic       pump_up;
    logic       pump_dn;
    logic       pump_hiz;
    logic [1:0] pump_isel;
    logic       lock_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Bit layout: [5]=up [4]=dn [3]=hiz [2]=lock [1:0]=isel
    typedef struct {
        int         cyc;
        logic [5:0] mask;
        logic [5:0] val;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [5:0] hist[int];

    pfd_lock_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fdiv_in   (fdiv_in),
        .fref_in   (fref_in),
        .cp_sel    (cp_sel),
        .test_code (test_code),
        .pump_up   (pump_up),
        .pump_dn   (pump_dn),
        .pump_hiz  (pump_hiz),
        .pump_isel (pump_isel),
        .lock_flag (lock_flag)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int c, input logic [5:0] m, input logic [5:0] v, input string tag);
        exp_t e;
        e.cyc = c; e.mask = m; e.val = v; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic push_pump(input int c, input logic up, input logic dn, input logic hz, input string tag);
        push(c, 6'b111000, {up, dn, hz, 3'b000}, tag);
    endtask

    task automatic push_lock(input int c, input logic v, input string tag);
        push(c, 6'b000100, {3'b000, v, 2'b00}, tag);
    endtask

    // Monitor: log outputs each cycle, then compare every due item.
    initial begin
        forever begin
            @(negedge clk);
            hist[cyc] = {pump_up, pump_dn, pump_hiz, lock_flag, pump_isel};
            while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
                exp_t e;
                logic [5:0] act;
                e = sb_q.pop_front();
                act = hist[e.cyc];
                checks++;
                if ((act & e.mask) !== (e.val & e.mask)) begin
                    errors++;
                    $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                             e.tag, e.cyc, act & e.mask, e.val & e.mask, e.mask);
                end
            end
        end
    end

    // One reference period. skew>0: div falls first; skew<0: ref first.
    task automatic run_period(input int skew, input bit forced, output int t0, output int rf);
        int mag;
        repeat (2) @(negedge clk);
        t0  = cyc;
        mag = (skew < 0) ? -skew : skew;
        rf  = (skew >= 0) ? t0 + mag : t0;
        for (int k = 1; k <= mag; k++) begin
            if (forced)
                push_pump(t0 + k, 1'b0, 1'b0, 1'b1, "R6 forced idle");
            else if (skew > 0)
                push_pump(t0 + k, 1'b1, 1'b0, 1'b0, "R2 up pulse");
            else
                push_pump(t0 + k, 1'b0, 1'b1, 1'b0, "R3 down pulse");
        end
        push_pump(t0 + mag + 1, 1'b0, 1'b0, 1'b1, (mag == 0) ? "R4 coincident" : "R5 release");
        push_pump(t0 + mag + 2, 1'b0, 1'b0, 1'b1, "R5 stays idle");
        if (skew >= 0) fdiv_in = 1'b0; else fref_in = 1'b0;
        if (mag > 0) repeat (mag) @(negedge clk);
        fdiv_in = 1'b0;
        fref_in = 1'b0;
        repeat (4) @(negedge clk);
        fdiv_in = 1'b1;
        fref_in = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // Run n clean periods; check lock low after the (n-1)th and the given value after the nth.
    task automatic clean_run(input int n, input logic last_lock, input string tag);
        int t0, rf;
        for (int i = 1; i <= n; i++) begin
            run_period(0, 1'b0, t0, rf);
            if (i == n - 1) push_lock(rf + 1, 1'b0, tag);
            if (i == n)     push_lock(rf + 1, last_lock, tag);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0, rf;
        // R1: reset state, sampled during reset.
        push(2, 6'b111111, 6'b001000, "R1 reset state");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4 / R9: eight coincident (clean) periods bring lock.
        clean_run(8, 1'b1, "R9 lock after eighth clean edge");

        // R2 width 1 keeps lock (R9 one-cycle pulse is clean).
        run_period(1, 1'b0, t0, rf);
        push_lock(rf + 1, 1'b1, "R9 one-cycle pulse clean");
        // R3 width 1.
        run_period(-1, 1'b0, t0, rf);
        push_lock(rf + 2, 1'b1, "R9 one-cycle down clean");

        // R8: width-3 UP pulse drops lock.
        run_period(3, 1'b0, t0, rf);
        push_lock(t0 + 2, 1'b1, "R8 lock held in first cycles");
        push_lock(t0 + 3, 1'b0, "R8 lock dropped");

        // R10: five clean, then a wide pulse, then eight more needed.
        clean_run(5, 1'b0, "R10 still unlocked");
        run_period(2, 1'b0, t0, rf);
        push_lock(rf + 1, 1'b0, "R10 wide period");
        clean_run(8, 1'b1, "R10 relock after restart");

        // R3 / R8: width-3 DOWN pulse drops lock.
        run_period(-3, 1'b0, t0, rf);
        push_lock(t0 + 2, 1'b1, "R8 lock held before second down cycle");
        push_lock(t0 + 3, 1'b0, "R8 down pulse drops lock");

        // R7: current select follows {cp_sel, test_code[0]}.
        @(negedge clk); cp_sel = 1'b1; test_code = 3'b000;
        push(cyc + 1, 6'b000011, 6'b000010, "R7 isel 2");
        @(negedge clk); cp_sel = 1'b0; test_code = 3'b001;
        push(cyc + 1, 6'b000011, 6'b000001, "R7 isel 1");
        @(negedge clk); cp_sel = 1'b1; test_code = 3'b011;
        push(cyc + 1, 6'b000011, 6'b000011, "R7 isel 3");
        @(negedge clk); cp_sel = 1'b0; test_code = 3'b000;
        push(cyc + 1, 6'b000011, 6'b000000, "R7 isel 0");

        // R6: forced idle hides an UP pulse and then a DOWN pulse.
        @(negedge clk); test_code = 3'b010;
        run_period(3, 1'b1, t0, rf);
        run_period(-2, 1'b1, t0, rf);
        @(negedge clk); test_code = 3'b000;
        run_period(2, 1'b0, t0, rf);

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL drain: actual %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule